// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block arbitrates interrupt requests from eight sources and hands the core one vector at a time. The sources are four active-low external pins, three timer request lines and a serial-port request line. Each source has an enable bit and a one-bit priority. The external pins pass through a synchronizer. Each pin then works in one of two modes. In falling-edge mode the block latches a pending flag. In low-level mode the pending state follows the pin.

Among the eligible sources, the block first prefers the high priority level. Within a level it uses a fixed polling order. It then raises a request with the winner's vector. The core takes the vector with an acknowledge pulse and later reports the end of the handler with a return pulse. The block tracks which priority levels are in service. A high-priority request can preempt a low-priority handler. A request at the same or a lower level waits until the return pulse.

The two upper external sources have no separate control inputs. Their priority, enable, trigger type and pending flag are packed into one 8-bit control register. Software writes that register and reads it back.

Two states drive the request:
- `ST_IDLE`: no request is posted.
- `ST_POST`: a request is posted and its vector is held.

The transitions are:
- IDLE→POST (*post*): an eligible winner exists. The winner's index is latched.
- POST→IDLE (*take*): the core acknowledges. An edge flag is cleared and the level is marked in service.
- POST→IDLE (*withdraw*): the latched source is no longer eligible.
- POST→IDLE (*bump*): a high-level request appears while a low-level source is posted. The request is posted again on the next cycle with the new winner.

Top module: `irq_arbiter8`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` is 00h, no level is in service and `xctl_q` reads 00h while all pins are high.
- R2: Polling order is index 0 to 7: EXT0, T0, EXT1, T1, SER, T2, EXT2, EXT3. The vector is 03h plus eight times the index, giving 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h and 3Bh. `irq_vec` is 00h while no request is posted.
- R3: In edge mode a falling edge on a pin sets a pending flag. The flag stays set after the pin returns high. `irq_req` rises on the fourth rising clock edge after the pin falls.
- R4: In level mode the source is pending while the synchronized pin is low, and nothing is latched. `irq_req` rises on the third clock edge after the pin falls. If the pin is released before acknowledge, `irq_req` falls on the third clock edge after release.
- R5: An eligible high-priority source wins over any low-priority source, whatever its polling position. If a high-priority request appears while a low-priority one is posted, the posted request is replaced.
- R6: Among eligible sources of the same level, the one with the lowest index wins.
- R7: A disabled source is never requested. Its edge flag is still latched and is visible in `xctl_q`.
- R8: While a low-level handler is in service, only high-priority sources are requested. While a high-level handler is in service, nothing is requested.
- R9: A return pulse releases the high level if it is in service, otherwise the low level.
- R10: While `irq_req` is high and no acknowledge arrives, `irq_vec` stays constant. An acknowledge clears the taken source's edge flag and drops `irq_req` at once.
- R11: The control register layout is: bit 7 PX3 (priority of EXT3, 1 = high), bit 6 EX3 (enable), bit 5 IE3 (flag), bit 4 IT3 (1 = falling edge, 0 = low level), and bits 3 to 0 the same four fields for EXT2. Writing an IE bit in edge mode loads the flag. In level mode the IE bit reads back the synchronized pin state, low giving 1.
- R12: The timer and serial request inputs are already in the clock domain and are used directly. A new request is posted one clock edge after it appears. The block never clears these inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 4 | External pins, active low: [0] EXT0, [1] EXT1, [2] EXT2, [3] EXT3 |
| ext01_edge | input | 2 | Trigger type for EXT0/EXT1: 1 = falling edge, 0 = low level |
| periph_req | input | 4 | Peripheral requests: [0] T0, [1] T1, [2] SER, [3] T2 |
| std_en | input | 6 | Enables for polling indices 0 to 5 |
| std_pri | input | 6 | Priorities for polling indices 0 to 5 (1 = high) |
| xctl_we | input | 1 | Write strobe for the packed control register |
| xctl_wdata | input | 8 | Write data for the packed control register |
| xctl_q | output | 8 | Readback of the packed control register with live flags |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the posted request |
| irq_ack | input | 1 | Core takes the posted vector |
| irq_reti | input | 1 | Core returns from a handler |

## Verification
The assertions check the rules that must hold on every cycle:
- the vector stays stable while a request waits;
- every vector has the legal form;
- nothing is requested while the high level is in service;
- a return pulse releases the high level;
- a latched edge flag survives until it is acknowledged or rewritten.

Some behaviour can only be shown by the bench's scenarios:
- the exact latencies through the synchronizer;
- the arbitration outcome for given mixes of enables and priorities;
- the preemption and nesting sequences;
- the withdrawal of a released level request;
- the contents of the packed register.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
    localparam int NSRC = 8;
    localparam int IDXW = $clog2(NSRC);
    localparam int NEXT = 4;
    localparam int NPER = 4;
    localparam int NSTD = 6;
    localparam logic [7:0] VEC_BASE = 8'h03;
    localparam int VEC_STEP = 8;

    // bit positions inside the packed control register (decoded by software)
    localparam int XB_IT2 = 0;
    localparam int XB_IE2 = 1;
    localparam int XB_EX2 = 2;
    localparam int XB_PX2 = 3;
    localparam int XB_IT3 = 4;
    localparam int XB_IE3 = 5;
    localparam int XB_EX3 = 6;
    localparam int XB_PX3 = 7;

    typedef enum logic [0:0] {ST_IDLE, ST_POST} arb_state_t;

    // polling index of external pin k
    function automatic int ext_slot(input int k);
        case (k)
            0: return 0;
            1: return 2;
            2: return 6;
            default: return 7;
        endcase
    endfunction

    // polling index of peripheral request j
    function automatic int per_slot(input int j);
        case (j)
            0: return 1;
            1: return 3;
            2: return 4;
            default: return 5;
        endcase
    endfunction

    // lowest set index of a mask
    function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] m);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m[i]) r = IDXW'(i);
        end
        return r;
    endfunction

    function automatic logic [7:0] vec_of(input logic [IDXW-1:0] idx);
        return VEC_BASE + 8'(int'(idx) * VEC_STEP);
    endfunction
endpackage

// File: rtl/irq8_ext_detect.sv
module irq8_ext_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    input  logic sw_we,
    input  logic sw_val,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic prev_q;
    logic flag_q;
    logic pin_s;
    logic fall;

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign fall  = prev_q & ~pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= pin_s;
        end
    end

    // hardware set wins over software load and over the take clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (!edge_mode) flag_q <= 1'b0;
        else if (fall)       flag_q <= 1'b1;
        else if (sw_we)      flag_q <= sw_val;
        else if (clr)        flag_q <= 1'b0;
    end

    assign pend = edge_mode ? flag_q : ~pin_s;

    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag_q && !clr && !sw_we) |=> (flag_q || !edge_mode));
    a_r3_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> (flag_q || !edge_mode));
endmodule

// File: rtl/irq8_xctl.sv
module irq8_xctl
    import irq8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic [1:0] pend,
    output logic [1:0] px,
    output logic [1:0] ex,
    output logic [1:0] it,
    output logic       ie_we,
    output logic [1:0] ie_val,
    output logic [7:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px <= '0;
            ex <= '0;
            it <= '0;
        end else if (we) begin
            px <= {wdata[XB_PX3], wdata[XB_PX2]};
            ex <= {wdata[XB_EX3], wdata[XB_EX2]};
            it <= {wdata[XB_IT3], wdata[XB_IT2]};
        end
    end

    assign ie_we  = we;
    assign ie_val = {wdata[XB_IE3], wdata[XB_IE2]};

    always_comb begin
        rdata         = '0;
        rdata[XB_PX3] = px[1];
        rdata[XB_EX3] = ex[1];
        rdata[XB_IE3] = pend[1];
        rdata[XB_IT3] = it[1];
        rdata[XB_PX2] = px[0];
        rdata[XB_EX2] = ex[0];
        rdata[XB_IE2] = pend[0];
        rdata[XB_IT2] = it[0];
    end
endmodule

// File: rtl/irq8_select.sv
module irq8_select
    import irq8_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] pri,
    input  logic            act_hi,
    input  logic            act_lo,
    output logic [NSRC-1:0] elig,
    output logic            win_valid,
    output logic            win_hi,
    output logic [IDXW-1:0] win_idx
);
    logic [NSRC-1:0] hi_mask;
    logic [NSRC-1:0] lo_mask;

    for (genvar i = 0; i < NSRC; i++) begin : g_elig
        assign elig[i] = pend[i] && en[i] &&
                         (pri[i] ? !act_hi : (!act_hi && !act_lo));
    end

    assign hi_mask   = elig & pri;
    assign lo_mask   = elig & ~pri;
    assign win_hi    = |hi_mask;
    assign win_valid = |elig;
    assign win_idx   = win_hi ? first_set(hi_mask) : first_set(lo_mask);
endmodule

// File: rtl/irq_arbiter8.sv
module irq_arbiter8
    import irq8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [1:0]       ext01_edge,
    input  logic [NPER-1:0]  periph_req,
    input  logic [NSTD-1:0]  std_en,
    input  logic [NSTD-1:0]  std_pri,
    input  logic             xctl_we,
    input  logic [7:0]       xctl_wdata,
    output logic [7:0]       xctl_q,
    output logic             irq_req,
    output logic [7:0]       irq_vec,
    input  logic             irq_ack,
    input  logic             irq_reti
);
    arb_state_t       state_q, state_d;
    logic [IDXW-1:0]  cur_idx_q, cur_idx_d;
    logic             act_hi_q, act_lo_q, act_hi_d, act_lo_d;
    logic             take;

    logic [NSRC-1:0]  pend_all, en_all, pri_all, elig;
    logic             win_valid, win_hi;
    logic [IDXW-1:0]  win_idx;

    logic [NEXT-1:0]  ext_pend, ext_clr;
    logic [1:0]       x_px, x_ex, x_it, x_ie_val;
    logic             x_ie_we;

    irq8_xctl u_xctl (
        .clk(clk), .rst_n(rst_n), .we(xctl_we), .wdata(xctl_wdata),
        .pend(ext_pend[3:2]), .px(x_px), .ex(x_ex), .it(x_it),
        .ie_we(x_ie_we), .ie_val(x_ie_val), .rdata(xctl_q)
    );

    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        logic mode_k, swwe_k, swval_k;
        if (k < 2) begin : g_in
            assign mode_k  = ext01_edge[k];
            assign swwe_k  = 1'b0;
            assign swval_k = 1'b0;
        end else begin : g_reg
            assign mode_k  = x_it[k-2];
            assign swwe_k  = x_ie_we;
            assign swval_k = x_ie_val[k-2];
        end
        assign ext_clr[k] = take && (cur_idx_q == IDXW'(ext_slot(k)));
        irq8_ext_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk(clk), .rst_n(rst_n), .pin_n(ext_pin_n[k]),
            .edge_mode(mode_k), .clr(ext_clr[k]),
            .sw_we(swwe_k), .sw_val(swval_k), .pend(ext_pend[k])
        );
        assign pend_all[ext_slot(k)] = ext_pend[k];
    end

    for (genvar j = 0; j < NPER; j++) begin : g_per
        assign pend_all[per_slot(j)] = periph_req[j];
    end

    assign en_all  = {x_ex, std_en};
    assign pri_all = {x_px, std_pri};

    irq8_select u_sel (
        .pend(pend_all), .en(en_all), .pri(pri_all),
        .act_hi(act_hi_q), .act_lo(act_lo_q), .elig(elig),
        .win_valid(win_valid), .win_hi(win_hi), .win_idx(win_idx)
    );

    // next state
    always_comb begin
        state_d   = state_q;
        cur_idx_d = cur_idx_q;
        take      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) begin
                    state_d   = ST_POST;
                    cur_idx_d = win_idx;
                end
            end
            ST_POST: begin
                if (irq_ack) begin
                    state_d = ST_IDLE;
                    take    = 1'b1;
                end else if (!elig[cur_idx_q] || (win_hi && !pri_all[cur_idx_q])) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // in-service levels: return releases first, then take marks
    always_comb begin
        act_hi_d = act_hi_q;
        act_lo_d = act_lo_q;
        if (irq_reti) begin
            if (act_hi_q) act_hi_d = 1'b0;
            else          act_lo_d = 1'b0;
        end
        if (take) begin
            if (pri_all[cur_idx_q]) act_hi_d = 1'b1;
            else                    act_lo_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_idx_q <= '0;
            act_hi_q  <= 1'b0;
            act_lo_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            cur_idx_q <= cur_idx_d;
            act_hi_q  <= act_hi_d;
            act_lo_q  <= act_lo_d;
        end
    end

    // outputs
    always_comb begin
        irq_req = (state_q == ST_POST);
        irq_vec = irq_req ? vec_of(cur_idx_q) : 8'h00;
    end

    a_r10_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_vec)));
    a_r2_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[7:6] == 2'b00));
    a_r8_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi_q |-> !irq_req);
    a_r9_reti_releases_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti && act_hi_q && !irq_ack) |=> !act_hi_q);
endmodule

// File: tb/test_irq_arbiter8.sv
`timescale 1ns/1ps
module test_irq_arbiter8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_pin_n = 4'hF;
    logic [1:0] ext01_edge = 2'b00;
    logic [3:0] periph_req = 4'h0;
    logic [5:0] std_en = 6'h00;
    logic [5:0] std_pri = 6'h00;
    logic       xctl_we = 1'b0;
    logic [7:0] xctl_wdata = 8'h00;
    logic [7:0] xctl_q;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0;
    logic       irq_reti = 1'b0;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    irq_arbiter8 i_irq_arbiter8 (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext01_edge(ext01_edge),
        .periph_req(periph_req), .std_en(std_en), .std_pri(std_pri),
        .xctl_we(xctl_we), .xctl_wdata(xctl_wdata), .xctl_q(xctl_q),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xwrite(input logic [7:0] v);
        xctl_wdata = v;
        xctl_we = 1'b1;
        @(negedge clk);
        xctl_we = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic reti_pulse();
        irq_reti = 1'b1;
        @(negedge clk);
        irq_reti = 1'b0;
    endtask

    // bench model of arbitration: returns {valid, vector}
    function automatic logic [8:0] model(input logic [7:0] p, input logic [7:0] e,
                                         input logic [7:0] h);
        for (int i = 0; i < 8; i++)
            if (p[i] && e[i] && h[i]) return {1'b1, 8'(3 + 8 * i)};
        for (int i = 0; i < 8; i++)
            if (p[i] && e[i] && !h[i]) return {1'b1, 8'(3 + 8 * i)};
        return 9'h000;
    endfunction

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [8:0] m;
        logic [7:0] p8;
        seed = 32'd2024;
        void'($urandom(seed));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk("R1 req", irq_req, 0);
        chk("R1 vec", irq_vec, 8'h00);
        chk("R1 xctl", xctl_q, 8'h00);

        // R3 edge on EXT0
        ext01_edge = 2'b01; std_en = 6'b000001;
        wait_n(3);
        ext_pin_n[0] = 1'b0;
        wait_n(3);
        chk("R3 not yet", irq_req, 0);
        wait_n(1);
        chk("R3 req", irq_req, 1);
        chk("R2 vec EXT0", irq_vec, 8'h03);
        ext_pin_n[0] = 1'b1;
        wait_n(5);
        chk("R3 latched", irq_req, 1);
        ack_pulse();
        chk("R10 ack drops req", irq_req, 0);
        reti_pulse();
        wait_n(4);
        chk("R10 flag cleared", irq_req, 0);

        // R4 level on EXT1
        ext01_edge = 2'b00; std_en = 6'b000100;
        wait_n(2);
        ext_pin_n[1] = 1'b0;
        wait_n(2);
        chk("R4 not yet", irq_req, 0);
        wait_n(1);
        chk("R4 req", irq_req, 1);
        chk("R2 vec EXT1", irq_vec, 8'h13);
        ext_pin_n[1] = 1'b1;
        wait_n(2);
        chk("R4 still", irq_req, 1);
        wait_n(1);
        chk("R4 withdrawn", irq_req, 0);

        // R5 / R6 arbitration
        std_en = 6'b111111; std_pri = 6'b100000; periph_req = 4'b1001;
        wait_n(1);
        chk("R5 T2 high over T0", irq_vec, 8'h2B);
        periph_req = 4'h0; wait_n(2);
        std_pri = 6'b000000; periph_req = 4'b0011;
        wait_n(1);
        chk("R6 T0 before T1", irq_vec, 8'h0B);
        periph_req = 4'h0; wait_n(2);
        periph_req = 4'b1100;
        wait_n(1);
        chk("R6 SER before T2", irq_vec, 8'h23);
        periph_req = 4'h0; wait_n(2);
        std_pri = 6'b001000; periph_req = 4'b0011;
        wait_n(1);
        chk("R5 T1 high over T0", irq_vec, 8'h1B);
        periph_req = 4'h0; std_en = 6'h00; std_pri = 6'h00; wait_n(2);

        // R7 / R11 EXT2 via packed register
        xwrite(8'h01);
        ext_pin_n[2] = 1'b0; wait_n(3); ext_pin_n[2] = 1'b1;
        wait_n(4);
        chk("R7 disabled no req", irq_req, 0);
        chk("R7 flag visible", xctl_q, 8'h03);
        xwrite(8'h07);
        wait_n(1);
        chk("R11 enable req", irq_req, 1);
        chk("R2 vec EXT2", irq_vec, 8'h33);
        xwrite(8'h05);
        chk("R11 sw clear flag", xctl_q, 8'h05);
        wait_n(1);
        chk("R11 withdrawn", irq_req, 0);
        xwrite(8'h00);

        // R5 bump: EXT3 high level replaces posted low T0
        std_en = 6'b000010; periph_req = 4'b0001;
        xwrite(8'hC0);
        chk("R12 T0 posted", irq_vec, 8'h0B);
        ext_pin_n[3] = 1'b0;
        wait_n(2);
        chk("R11 level readback", xctl_q, 8'hE0);
        wait_n(2);
        chk("R5 bump to EXT3", irq_vec, 8'h3B);
        ext_pin_n[3] = 1'b1; periph_req = 4'h0;
        xwrite(8'h00);
        wait_n(3);

        // R8 / R9 nesting
        std_en = 6'b100010; std_pri = 6'b100000; periph_req = 4'b0001;
        wait_n(1);
        chk("R12 T0 one cycle", irq_vec, 8'h0B);
        ack_pulse();
        wait_n(3);
        chk("R8 same level waits", irq_req, 0);
        periph_req = 4'b1001;
        wait_n(1);
        chk("R8 preempt", irq_vec, 8'h2B);
        ack_pulse();
        wait_n(2);
        chk("R8 hi blocks", irq_req, 0);
        reti_pulse();
        wait_n(1);
        chk("R9 hi released only", irq_vec, 8'h2B);
        ack_pulse();
        periph_req = 4'b0001;
        reti_pulse();
        wait_n(1);
        chk("R9 lo still busy", irq_req, 0);
        reti_pulse();
        wait_n(1);
        chk("R9 lo released", irq_vec, 8'h0B);
        periph_req = 4'h0; std_en = 6'h00; std_pri = 6'h00;
        wait_n(3);

        // R2/R5/R6/R12 random arbitration of the peripheral lines
        for (int it = 0; it < 40; it++) begin
            periph_req = 4'h0; wait_n(2);
            std_en = 6'($urandom); std_pri = 6'($urandom);
            periph_req = 4'($urandom);
            p8 = 8'h00;
            p8[1] = periph_req[0]; p8[3] = periph_req[1];
            p8[4] = periph_req[2]; p8[5] = periph_req[3];
            m = model(p8, {2'b00, std_en}, {2'b00, std_pri});
            wait_n(1);
            chk("R6 random req", irq_req, m[8]);
            chk("R5 random vec", irq_vec, m[8] ? m[7:0] : 8'h00);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule